// File: doc/BRIEF.md
# Multicycle Stepped Processor Core

This block is a small processor core for a load/store subset of a classic 32-bit three-register instruction format. It handles word loads and stores, the register-to-register operations add, subtract, and, or and set-on-less-than, and branch-if-equal. Each instruction is carried out as a chain of one-cycle steps: fetch, decode, execute, memory and write-back. An instruction performs only the steps it needs, so a branch takes three cycles, a register operation or a store four, and a load five.

A single word-wide memory holds both code and data. One arithmetic unit serves every step. It increments the program counter during fetch, forms the branch target during decode, and does the real work during execute. A control state machine sequences the steps and drives every register enable and multiplexer select.

A load port writes the memory while the core is held in reset. A set of debug outputs shows the program counter, marks each fetch cycle, and reports every register-file write.

Top module: `mc_core`

## Requirements
- R1: Synchronous active-high `rst` sets the program counter to 0, puts the sequencer in the fetch step (`dbg_fetch` = 1), and clears all 32 registers to zero.
- R2: Counted from one fetch cycle to the next, a branch (opcode 0x04) takes 3 cycles, a register operation (opcode 0x00) 4, a store (opcode 0x2B) 4 and a load (opcode 0x23) 5. `dbg_fetch` is high exactly in the first cycle of each instruction, and a register write always happens in an instruction's last cycle.
- R3: The fetch step captures the word at byte address `pc`, read from word index pc[ADDR_W+1:2]. Unless a taken branch intervenes, the next instruction is fetched from pc+4.
- R4: A register operation (opcode bits [31:26] = 0x00) writes rd (bits [15:11]) with the result of rs (bits [25:21]) and rt (bits [20:16]). The function field (bits [5:0]) selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed less-than giving 1 or 0.
- R5: A load (0x23) writes rt with the memory word at byte address rs + sign-extended bits [15:0].
- R6: A store (0x2B) writes register rt to the memory word at byte address rs + sign-extended bits [15:0]. A later load from that address returns the stored value.
- R7: A branch (0x04) whose rs and rt values are equal moves the program counter to pc+4 + (sign-extended bits [15:0] << 2). When they differ, execution continues at pc+4.
- R8: Register 0 always reads as zero. A write addressed to it is dropped and does not raise `dbg_wr_en`.
- R9: With `ld_en` = 1, `ld_data` is written at the next rising edge to memory word `ld_addr`. Code and data both live in that one memory.
- R10: Any other opcode leaves registers and memory unchanged and returns to fetch after 2 cycles, continuing at pc+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Memory load strobe |
| ld_addr | input | ADDR_W | Word index for the load port |
| ld_data | input | 32 | Word written by the load port |
| dbg_pc | output | 32 | Current program counter (byte address) |
| dbg_fetch | output | 1 | High during the fetch step |
| dbg_wr_en | output | 1 | A nonzero register is written this cycle |
| dbg_wr_reg | output | 5 | Register number being written |
| dbg_wr_data | output | 32 | Value being written |

## Verification
The hardest situation to reach from the ports is a store whose effect becomes visible only through a later load. The address for that store is computed from a register that was itself loaded from memory. A directed prefix sets this up by loading a pointer word, storing through it, reloading it and branching on the comparison. A seeded random body then mixes loads, stores, register operations and short forward branches over a few registers, so that equal operands, and therefore taken branches, occur often. Every fetch address, step count and register write is compared with an instruction-level model held in the bench.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN = 32;

  typedef enum logic [2:0] {ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB} step_t;
  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} aluop_t;
  typedef enum logic [1:0] {SRCB_REG, SRCB_FOUR, SRCB_IMM, SRCB_BR} srcb_t;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef struct packed {
    logic   pc_we;     // load pc from the ALU result
    logic   pc_cond;   // load pc from out_q when the ALU result is zero
    logic   iord;      // memory address: 0 = pc, 1 = out_q
    logic   ir_we;
    logic   mem_we;
    logic   ab_we;
    logic   out_we;
    logic   mdr_we;
    logic   srca_reg;  // ALU A: 0 = pc, 1 = a_q
    srcb_t  srcb;
    aluop_t op;
    logic   reg_we;
    logic   dst_rd;    // write register: 0 = rt, 1 = rd
    logic   wd_mem;    // write value: 0 = out_q, 1 = mdr
  } ctl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic aluop_t funct_to_op(input logic [5:0] fn);
    case (fn)
      FN_SUB:  return ALU_SUB;
      FN_AND:  return ALU_AND;
      FN_OR:   return ALU_OR;
      FN_SLT:  return ALU_SLT;
      default: return ALU_ADD;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input aluop_t op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (op)
      ALU_SUB: return a - b;
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_SLT: return ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
      default: return a + b;
    endcase
  endfunction
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
(
  input  aluop_t           op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic [XLEN-1:0]  y,
  output logic             zero
);
  assign y    = alu_eval(op, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
#(
  parameter int REGS = 32,
  localparam int RA_W = $clog2(REGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RA_W-1:0] ra1,
  input  logic [RA_W-1:0] ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  input  logic            we,
  input  logic [RA_W-1:0] wa,
  input  logic [XLEN-1:0] wd,
  output logic            wr_fire
);
  logic [XLEN-1:0] bank [REGS];

  for (genvar g = 0; g < REGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign bank[g] = '0;
    end else begin : g_live
      always_ff @(posedge clk) begin
        if (rst)                          bank[g] <= '0;
        else if (we && wa == RA_W'(g))    bank[g] <= wd;
      end
    end
  end

  assign rd1     = bank[ra1];
  assign rd2     = bank[ra2];
  assign wr_fire = we && (wa != '0);
endmodule

// File: rtl/mc_mem.sv
module mc_mem
  import mc_pkg::*;
#(
  parameter int WORDS = 256,
  localparam int AW = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic [AW-1:0]   ridx,
  output logic [XLEN-1:0] rdata,
  input  logic            we,
  input  logic [AW-1:0]   widx,
  input  logic [XLEN-1:0] wdata,
  input  logic            ld_en,
  input  logic [AW-1:0]   ld_idx,
  input  logic [XLEN-1:0] ld_data
);
  logic [XLEN-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (ld_en)   cells[ld_idx] <= ld_data;
    else if (we) cells[widx]   <= wdata;
  end

  assign rdata = cells[ridx];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output step_t      step,
  output ctl_t       ctl
);
  step_t nxt;
  logic  known_op;

  assign known_op = (opcode == OP_RTYPE) || (opcode == OP_LOAD) ||
                    (opcode == OP_STORE) || (opcode == OP_BEQ);

  always_ff @(posedge clk) begin
    if (rst) step <= ST_FETCH;
    else     step <= nxt;
  end

  always_comb begin
    ctl = '0;
    nxt = ST_FETCH;
    case (step)
      ST_FETCH: begin
        ctl.ir_we = 1'b1;
        ctl.pc_we = 1'b1;
        ctl.srcb  = SRCB_FOUR;
        ctl.op    = ALU_ADD;
        nxt       = ST_DECODE;
      end
      ST_DECODE: begin
        ctl.ab_we  = 1'b1;
        ctl.out_we = 1'b1;
        ctl.srcb   = SRCB_BR;
        ctl.op     = ALU_ADD;
        nxt        = known_op ? ST_EXEC : ST_FETCH;
      end
      ST_EXEC: begin
        ctl.srca_reg = 1'b1;
        if (opcode == OP_BEQ) begin
          ctl.srcb    = SRCB_REG;
          ctl.op      = ALU_SUB;
          ctl.pc_cond = 1'b1;
          nxt         = ST_FETCH;
        end else if (opcode == OP_RTYPE) begin
          ctl.srcb   = SRCB_REG;
          ctl.op     = funct_to_op(funct);
          ctl.out_we = 1'b1;
          nxt        = ST_WB;
        end else begin
          ctl.srcb   = SRCB_IMM;
          ctl.op     = ALU_ADD;
          ctl.out_we = 1'b1;
          nxt        = ST_MEM;
        end
      end
      ST_MEM: begin
        ctl.iord = 1'b1;
        if (opcode == OP_STORE) begin
          ctl.mem_we = 1'b1;
          nxt        = ST_FETCH;
        end else begin
          ctl.mdr_we = 1'b1;
          nxt        = ST_WB;
        end
      end
      ST_WB: begin
        ctl.reg_we = 1'b1;
        ctl.dst_rd = (opcode == OP_RTYPE);
        ctl.wd_mem = (opcode == OP_LOAD);
        nxt        = ST_FETCH;
      end
      default: nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int MEM_WORDS = 256,
  localparam int ADDR_W = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [XLEN-1:0]   ld_data,
  output logic [XLEN-1:0]   dbg_pc,
  output logic              dbg_fetch,
  output logic              dbg_wr_en,
  output logic [4:0]        dbg_wr_reg,
  output logic [XLEN-1:0]   dbg_wr_data
);
  step_t step;
  ctl_t  ctl;

  logic [XLEN-1:0] pc, ir, mdr, a_q, b_q, out_q;
  logic [XLEN-1:0] mem_rdata, rf_rd1, rf_rd2, alu_a, alu_b, alu_y, imm_ext;
  logic            alu_zero, wr_fire;
  logic [ADDR_W-1:0] mem_idx;
  logic [4:0]      wr_reg;
  logic [XLEN-1:0] wr_val;

  // Named internal events for the checker
  logic br_step;   // branch compare step
  logic br_taken;  // branch redirects pc this cycle

  mc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opcode(ir[31:26]), .funct(ir[5:0]),
    .step(step), .ctl(ctl)
  );

  assign mem_idx = ctl.iord ? out_q[ADDR_W+1:2] : pc[ADDR_W+1:2];

  mc_mem #(.WORDS(MEM_WORDS)) u_mem (
    .clk(clk), .ridx(mem_idx), .rdata(mem_rdata),
    .we(ctl.mem_we), .widx(out_q[ADDR_W+1:2]), .wdata(b_q),
    .ld_en(ld_en), .ld_idx(ld_addr), .ld_data(ld_data)
  );

  assign wr_reg = ctl.dst_rd ? ir[15:11] : ir[20:16];
  assign wr_val = ctl.wd_mem ? mdr : out_q;

  mc_regfile #(.REGS(32)) u_rf (
    .clk(clk), .rst(rst), .ra1(ir[25:21]), .ra2(ir[20:16]),
    .rd1(rf_rd1), .rd2(rf_rd2),
    .we(ctl.reg_we), .wa(wr_reg), .wd(wr_val), .wr_fire(wr_fire)
  );

  assign imm_ext = sext16(ir[15:0]);
  assign alu_a   = ctl.srca_reg ? a_q : pc;

  always_comb begin
    case (ctl.srcb)
      SRCB_REG:  alu_b = b_q;
      SRCB_FOUR: alu_b = XLEN'(4);
      SRCB_IMM:  alu_b = imm_ext;
      default:   alu_b = imm_ext << 2;
    endcase
  end

  mc_alu u_alu (.op(ctl.op), .a(alu_a), .b(alu_b), .y(alu_y), .zero(alu_zero));

  assign br_step  = ctl.pc_cond;
  assign br_taken = ctl.pc_cond && alu_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      ir    <= '0;
      mdr   <= '0;
      a_q   <= '0;
      b_q   <= '0;
      out_q <= '0;
    end else begin
      if (ctl.pc_we)       pc    <= alu_y;
      else if (br_taken)   pc    <= out_q;
      if (ctl.ir_we)       ir    <= mem_rdata;
      if (ctl.mdr_we)      mdr   <= mem_rdata;
      if (ctl.ab_we) begin
        a_q <= rf_rd1;
        b_q <= rf_rd2;
      end
      if (ctl.out_we)      out_q <= alu_y;
    end
  end

  assign dbg_pc      = pc;
  assign dbg_fetch   = (step == ST_FETCH);
  assign dbg_wr_en   = wr_fire;
  assign dbg_wr_reg  = wr_reg;
  assign dbg_wr_data = wr_val;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            fetch,
  input logic [XLEN-1:0] pc,
  input logic            wr_en,
  input logic            br_step
);
  logic [2:0] gap;

  always_ff @(posedge clk) begin
    if (rst)        gap <= '0;
    else if (fetch) gap <= 3'd1;
    else if (gap != 3'd7) gap <= gap + 3'd1;
  end

  // R1: first cycle out of reset is a fetch at address 0
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == '0 && fetch));

  // R2: fetch-to-fetch spacing is 2..5 cycles
  a_r2_step_gap: assert property (@(posedge clk) disable iff (rst)
    fetch |-> (gap == 3'd0 || (gap >= 3'd2 && gap <= 3'd5)));

  // R2: a register write ends the instruction
  a_r2_write_last: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> fetch);

  // R3: fetch advances pc by one word
  a_r3_pc_advance: assert property (@(posedge clk) disable iff (rst)
    fetch |=> pc == $past(pc) + XLEN'(4));

  // R7: pc moves only in fetch or in the branch compare step
  a_r7_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (!fetch && !br_step) |=> $stable(pc));
endmodule

bind mc_core mc_core_chk u_chk (
  .clk(clk), .rst(rst), .fetch(dbg_fetch), .pc(dbg_pc),
  .wr_en(dbg_wr_en), .br_step(br_step)
);

// File: tb/mc_core_test.sv
module mc_core_test;
  localparam int WORDS = 256;
  localparam int AW = 8;
  localparam int HALT_IDX = 106;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic [31:0]   dbg_pc, dbg_wr_data;
  logic          dbg_fetch, dbg_wr_en;
  logic [4:0]    dbg_wr_reg;

  always #5 clk = ~clk;

  mc_core #(.MEM_WORDS(WORDS)) uut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .dbg_pc(dbg_pc), .dbg_fetch(dbg_fetch), .dbg_wr_en(dbg_wr_en),
    .dbg_wr_reg(dbg_wr_reg), .dbg_wr_data(dbg_wr_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] mm [WORDS];
  logic [31:0] rr [32];
  logic [31:0] mpc;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] ref_op(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      6'h22:   return a + (~b + 32'd1);
      6'h24:   return a & b;
      6'h25:   return a | b;
      6'h2A:   return (a[31] != b[31]) ? {31'd0, a[31]} : {31'd0, a < b};
      default: return a + b;
    endcase
  endfunction

  function automatic logic [31:0] ext(input logic [15:0] v);
    return v[15] ? {16'hFFFF, v} : {16'h0000, v};
  endfunction

  // Program and data image
  task automatic build_image();
    logic [5:0] fns [5];
    fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
    for (int i = 0; i < WORDS; i++) mm[i] = 32'h0;
    for (int i = 128; i < 192; i++) mm[i] = $urandom;
    mm[128] = 32'h8000_0005;   // negative operand for signed compare
    mm[129] = 32'h0000_0007;
    mm[130] = 32'h0000_0240;   // pointer (word 144)
    mm[0]  = enc_i(6'h23, 0, 1, 512);
    mm[1]  = enc_i(6'h23, 0, 2, 516);
    mm[2]  = enc_i(6'h23, 0, 9, 520);
    mm[3]  = enc_r(1, 2, 3, 6'h22);
    mm[4]  = enc_r(1, 2, 4, 6'h2A);
    mm[5]  = enc_r(2, 1, 5, 6'h2A);
    mm[6]  = enc_r(1, 2, 0, 6'h20);        // write to register 0
    mm[7]  = enc_r(0, 1, 6, 6'h25);        // read register 0
    mm[8]  = enc_i(6'h2B, 9, 3, 8);        // store through pointer
    mm[9]  = enc_i(6'h23, 9, 7, 8);        // reload
    mm[10] = enc_i(6'h04, 7, 3, 1);        // taken
    mm[11] = enc_r(1, 1, 8, 6'h20);        // skipped
    mm[12] = enc_i(6'h04, 1, 2, 1);        // not taken
    mm[13] = enc_r(1, 2, 10, 6'h24);
    mm[14] = 32'hFC00_0000;                // unknown opcode
    mm[15] = enc_i(6'h23, 0, 0, 512);      // load into register 0
    for (int i = 16; i < HALT_IDX; i++) begin
      int k = int'($urandom % 10);
      if (k < 5)
        mm[i] = enc_r(int'($urandom % 8), int'($urandom % 8), int'($urandom % 8), fns[$urandom % 5]);
      else if (k < 7)
        mm[i] = enc_i(6'h23, 0, int'($urandom % 8), 512 + 4 * int'($urandom % 64));
      else if (k < 9)
        mm[i] = enc_i(6'h2B, 0, int'($urandom % 8), 512 + 4 * int'($urandom % 64));
      else begin
        int off = int'($urandom % 3);
        if (i + 1 + off > HALT_IDX) off = HALT_IDX - i - 1;
        mm[i] = enc_i(6'h04, int'($urandom % 4), int'($urandom % 4), off);
      end
    end
    mm[HALT_IDX] = enc_i(6'h04, 0, 0, -1);  // self loop
  endtask

  // Model state for one instruction
  int          exp_steps;
  string       cur_tag;
  bit          pend;
  logic [4:0]  pend_reg;
  logic [31:0] pend_val;
  string       pend_tag;

  task automatic model_step();
    logic [31:0] ins, addr, v;
    logic [4:0]  rs, rt, rd;
    ins = mm[mpc[9:2]];
    rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    addr = rr[rs] + ext(ins[15:0]);
    pend = 1'b0;
    case (ins[31:26])
      6'h00: begin
        exp_steps = 4; cur_tag = "R4";
        v = ref_op(ins[5:0], rr[rs], rr[rt]);
        if (rd != 0) begin pend = 1'b1; pend_reg = rd; pend_val = v; rr[rd] = v; end
        pend_tag = "R4";
        mpc = mpc + 32'd4;
      end
      6'h23: begin
        exp_steps = 5; cur_tag = "R5";
        v = mm[addr[9:2]];
        if (rt != 0) begin pend = 1'b1; pend_reg = rt; pend_val = v; rr[rt] = v; end
        pend_tag = (mpc == 0) ? "R9" : "R5";
        mpc = mpc + 32'd4;
      end
      6'h2B: begin
        exp_steps = 4; cur_tag = "R6";
        mm[addr[9:2]] = rr[rt];
        mpc = mpc + 32'd4;
      end
      6'h04: begin
        exp_steps = 3; cur_tag = "R7";
        if (rr[rs] == rr[rt]) mpc = mpc + 32'd4 + {ext(ins[15:0]), 2'b00};
        else                  mpc = mpc + 32'd4;
      end
      default: begin
        exp_steps = 2; cur_tag = "R10";
        mpc = mpc + 32'd4;
      end
    endcase
  endtask

  initial begin
    int cyc, last_fetch, nfetch;
    void'($urandom(32'd1234));
    build_image();
    for (int i = 0; i < 32; i++) rr[i] = 32'h0;
    for (int i = 0; i < WORDS; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = AW'(i); ld_data = mm[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(dbg_pc == 32'h0, "R1", "pc in reset", dbg_pc, 32'h0);
    check(dbg_fetch == 1'b1, "R1", "fetch in reset", {31'd0, dbg_fetch}, 32'd1);
    check(dbg_wr_en == 1'b0, "R1", "no write in reset", {31'd0, dbg_wr_en}, 32'd0);
    rst = 1'b0;
    mpc = 32'h0; cyc = 0; last_fetch = 0; nfetch = 0;
    cur_tag = "R3"; pend = 1'b0; pend_tag = "R4"; exp_steps = 0;
    forever begin
      if (dbg_wr_en) begin
        if (!pend) check(1'b0, "R8", "unexpected write", {27'd0, dbg_wr_reg}, 32'h0);
        else begin
          check(dbg_wr_reg == pend_reg, pend_tag, "write register", {27'd0, dbg_wr_reg}, {27'd0, pend_reg});
          check(dbg_wr_data == pend_val, pend_tag, "write value", dbg_wr_data, pend_val);
          pend = 1'b0;
        end
      end
      if (dbg_fetch) begin
        if (nfetch > 0) begin
          check(cyc - last_fetch == exp_steps, (cur_tag == "R10") ? "R10" : "R2",
                "step count", 32'(cyc - last_fetch), 32'(exp_steps));
          check(!pend, pend_tag, "missing write", {31'd0, pend}, 32'd0);
        end
        check(dbg_pc == mpc, (cur_tag == "R7") ? "R7" : "R3", "fetch address", dbg_pc, mpc);
        if (mpc == 32'(HALT_IDX * 4) || dbg_pc != mpc) break;
        model_step();
        last_fetch = cyc;
        nfetch++;
      end
      @(negedge clk);
      cyc++;
    end
    // R6 final memory image seen through the store pointer reload already; R1 mid-run reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(dbg_pc == 32'h0, "R1", "pc after late reset", dbg_pc, 32'h0);
    check(dbg_fetch == 1'b1, "R1", "fetch after late reset", {31'd0, dbg_fetch}, 32'd1);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule